// File: doc/BRIEF.md
# Multichannel Charge Sum, Peak Channel and Earliest Hit Reducer

This block takes sixteen parallel photomultiplier sample streams, one 10-bit unsigned sample per channel per clock, and turns them into one packed result word per clock for a downstream concentrator. It first corrects each channel on its own. The sample is scaled by a programmable per-channel gain, limited to the positive range of a signed 12-bit value, and reduced by a programmable per-channel pedestal. A negative result becomes zero.

The sixteen corrected values then go through a balanced binary tree with a register at every level. The tree produces three results together: the total charge, the channel holding the largest corrected value along with that value, and the smallest arrival time among the channels whose hit flag is set. The whole path, from the input samples to the result word, takes a fixed five clocks. This stays inside a six-period budget for first-stage processing. Gains and pedestals are loaded through a single-cycle write port.

Top module: `qsp_reduce_top`

## Requirements
- R1: The result word appears exactly 5 rising clock edges after the inputs that produced it are sampled, and a new word follows every clock. Its fields, with default parameters, are as follows: bit 38 is the hit flag, bits 37:30 the earliest time, bits 29:26 the peak channel index, bits 25:15 the peak value, and bits 14:0 the charge sum.
- R2: Each channel's corrected value is computed in this order: floor(sample × gain / 64), then limited to 2047, then minus the pedestal. A result below zero is replaced by 0.
- R3: The charge-sum field equals the sum of all sixteen corrected values.
- R4: The peak value field holds the largest corrected value, and the peak index field holds the channel that holds it.
- R5: When several channels share the largest corrected value, the lowest channel index is reported. This includes the case where every value is zero, which gives index 0.
- R6: When at least one hit flag is set, the hit flag field is 1 and the time field is the smallest arrival time among flagged channels. Times on unflagged channels have no effect.
- R7: When no hit flag is set, the hit flag field is 0 and the time field is 0.
- R8: A write with cfg_kind 0 loads cfg_data[7:0] as the gain of channel cfg_ch. A write with cfg_kind 1 loads cfg_data[9:0] as that channel's pedestal. The new value applies to samples taken on the edge that follows the write edge.
- R9: After reset every gain is 64 (unity), every pedestal is 0, and the result word is 0 while the inputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 160 | Sixteen 10-bit samples, channel k at bits 10k+9:10k |
| smp_hit | input | 16 | Per-channel hit flag |
| smp_time | input | 128 | Sixteen 8-bit arrival times, channel k at bits 8k+7:8k |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 selects gain, 1 selects pedestal |
| cfg_ch | input | 4 | Channel being written |
| cfg_data | input | 10 | Value being written |
| res_word | output | 39 | Packed result word |

## Verification
Assertions check the following on every cycle:
- each tree node keeps the larger peak of its two children, and prefers the left (lower-index) child on a tie;
- a flagged node time never exceeds the time of either flagged child;
- the output sum is never below the output peak value;
- a configuration write lands in the addressed register.

Only the bench scenarios can show the exact arithmetic of gain scaling, saturation and pedestal clamping, and the exact five-edge latency across back-to-back samples. The same holds for the no-hit encoding and for write timing measured against the samples that follow.

// File: rtl/qsp_pkg.sv
package qsp_pkg;
  typedef enum logic {
    CFG_GAIN = 1'b0,
    CFG_PED  = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/qsp_cal_regs.sv
module qsp_cal_regs #(
  parameter int NCH  = 16,
  parameter int SW   = 10,
  parameter int GW   = 8,
  parameter int GF   = 6,
  parameter int IW   = $clog2(NCH),
  parameter int CDW  = (GW > SW) ? GW : SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [IW-1:0]     cfg_ch,
  input  logic [CDW-1:0]    cfg_data,
  output logic [NCH*GW-1:0] gain_flat,
  output logic [NCH*SW-1:0] ped_flat
);
  import qsp_pkg::*;

  localparam logic [GW-1:0] GAIN_UNITY = GW'(1 << GF);

  logic [GW-1:0] gain_q [NCH];
  logic [GW-1:0] gain_d [NCH];
  logic [SW-1:0] ped_q  [NCH];
  logic [SW-1:0] ped_d  [NCH];

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      gain_d[k] = gain_q[k];
      ped_d[k]  = ped_q[k];
    end
    if (cfg_we) begin
      if (cfg_kind_e'(cfg_kind) == CFG_GAIN) gain_d[cfg_ch] = cfg_data[GW-1:0];
      else                                   ped_d[cfg_ch]  = cfg_data[SW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        gain_q[k] <= GAIN_UNITY;
        ped_q[k]  <= '0;
      end
    end else if (cfg_we) begin
      for (int k = 0; k < NCH; k++) begin
        gain_q[k] <= gain_d[k];
        ped_q[k]  <= ped_d[k];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_flat
      assign gain_flat[g*GW +: GW] = gain_q[g];
      assign ped_flat[g*SW +: SW]  = ped_q[g];
    end
  endgenerate

  // R8: a write lands in the addressed register
  a_r8_gain_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == 1'b0) |=> gain_q[$past(cfg_ch)] == $past(cfg_data[GW-1:0]));
  a_r8_ped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == 1'b1) |=> ped_q[$past(cfg_ch)] == $past(cfg_data[SW-1:0]));
endmodule

// File: rtl/qsp_chan_corr.sv
module qsp_chan_corr #(
  parameter int SW = 10,
  parameter int GW = 8,
  parameter int GF = 6,
  parameter int CW = 12,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] raw,
  input  logic [GW-1:0] gain,
  input  logic [SW-1:0] ped,
  input  logic          hit,
  input  logic [TW-1:0] tarr,
  output logic [CW-2:0] corr_q,
  output logic          hit_q,
  output logic [TW-1:0] tarr_q
);
  localparam int VW   = CW - 1;
  localparam int PW   = SW + GW;
  localparam int SHW  = PW - GF;
  localparam int EW   = (SHW > SW) ? SHW : SW;
  localparam int CMAX = (1 << VW) - 1;

  logic [PW-1:0]  prod;
  logic [SHW-1:0] scaled;
  logic [EW-1:0]  sat_e;
  logic [EW-1:0]  ped_e;
  logic [EW-1:0]  diff;
  logic [VW-1:0]  corr_d;

  always_comb begin
    prod   = PW'(raw) * PW'(gain);
    scaled = prod[PW-1:GF];
    if (EW'(scaled) > EW'(CMAX)) sat_e = EW'(CMAX);
    else                         sat_e = EW'(scaled);
    ped_e = EW'(ped);
    if (sat_e > ped_e) diff = sat_e - ped_e;
    else               diff = '0;
    corr_d = VW'(diff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
      hit_q  <= 1'b0;
      tarr_q <= '0;
    end else begin
      corr_q <= corr_d;
      hit_q  <= hit;
      tarr_q <= tarr;
    end
  end
endmodule

// File: rtl/qsp_merge_node.sv
module qsp_merge_node #(
  parameter int SUMW = 15,
  parameter int VW   = 11,
  parameter int IW   = 4,
  parameter int TW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SUMW-1:0] sum_a,
  input  logic [VW-1:0]   pk_a,
  input  logic [IW-1:0]   ix_a,
  input  logic            h_a,
  input  logic [TW-1:0]   t_a,
  input  logic [SUMW-1:0] sum_b,
  input  logic [VW-1:0]   pk_b,
  input  logic [IW-1:0]   ix_b,
  input  logic            h_b,
  input  logic [TW-1:0]   t_b,
  output logic [SUMW-1:0] sum_q,
  output logic [VW-1:0]   pk_q,
  output logic [IW-1:0]   ix_q,
  output logic            h_q,
  output logic [TW-1:0]   t_q
);
  logic [SUMW-1:0] sum_d;
  logic [VW-1:0]   pk_d;
  logic [IW-1:0]   ix_d;
  logic            h_d;
  logic [TW-1:0]   t_d;

  always_comb begin
    sum_d = sum_a + sum_b;
    if (pk_b > pk_a) begin
      pk_d = pk_b;
      ix_d = ix_b;
    end else begin
      pk_d = pk_a;
      ix_d = ix_a;
    end
    h_d = h_a | h_b;
    unique case ({h_a, h_b})
      2'b11:   t_d = (t_b < t_a) ? t_b : t_a;
      2'b10:   t_d = t_a;
      2'b01:   t_d = t_b;
      default: t_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      pk_q  <= '0;
      ix_q  <= '0;
      h_q   <= 1'b0;
      t_q   <= '0;
    end else begin
      sum_q <= sum_d;
      pk_q  <= pk_d;
      ix_q  <= ix_d;
      h_q   <= h_d;
      t_q   <= t_d;
    end
  end

  // R4: the kept peak is never below either child
  a_r4_peak_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) || (pk_q >= $past(pk_a) && pk_q >= $past(pk_b)));
  // R5: equal peaks keep the lower-index (left) child
  a_r5_tie_left: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(rst_n) && $past(pk_a) == $past(pk_b)) |-> ix_q == $past(ix_a));
  // R6: earliest time never exceeds a flagged child's time
  a_r6_time_min: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(rst_n) && $past(h_a) && $past(h_b)) |-> (t_q <= $past(t_a) && t_q <= $past(t_b)));
endmodule

// File: rtl/qsp_reduce_top.sv
module qsp_reduce_top #(
  parameter int NCH  = 16,
  parameter int SW   = 10,
  parameter int GW   = 8,
  parameter int GF   = 6,
  parameter int CW   = 12,
  parameter int TW   = 8,
  parameter int IW   = $clog2(NCH),
  parameter int CDW  = (GW > SW) ? GW : SW,
  parameter int VW   = CW - 1,
  parameter int SUMW = VW + IW,
  parameter int RW   = 1 + TW + IW + VW + SUMW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] smp_data,
  input  logic [NCH-1:0]    smp_hit,
  input  logic [NCH*TW-1:0] smp_time,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [IW-1:0]     cfg_ch,
  input  logic [CDW-1:0]    cfg_data,
  output logic [RW-1:0]     res_word
);
  localparam int NN = 2 * NCH;

  logic [NCH*GW-1:0] gain_flat;
  logic [NCH*SW-1:0] ped_flat;

  logic [SUMW-1:0] n_sum [NN-1:1];
  logic [VW-1:0]   n_pk  [NN-1:1];
  logic [IW-1:0]   n_ix  [NN-1:1];
  logic            n_h   [NN-1:1];
  logic [TW-1:0]   n_t   [NN-1:1];

  qsp_cal_regs #(.NCH(NCH), .SW(SW), .GW(GW), .GF(GF), .IW(IW), .CDW(CDW)) u_cal (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_ch(cfg_ch), .cfg_data(cfg_data),
    .gain_flat(gain_flat), .ped_flat(ped_flat)
  );

  genvar c, n;
  generate
    for (c = 0; c < NCH; c++) begin : g_leaf
      logic [VW-1:0] corr;
      qsp_chan_corr #(.SW(SW), .GW(GW), .GF(GF), .CW(CW), .TW(TW)) u_corr (
        .clk(clk), .rst_n(rst_n),
        .raw(smp_data[c*SW +: SW]), .gain(gain_flat[c*GW +: GW]),
        .ped(ped_flat[c*SW +: SW]), .hit(smp_hit[c]), .tarr(smp_time[c*TW +: TW]),
        .corr_q(corr), .hit_q(n_h[NCH+c]), .tarr_q(n_t[NCH+c])
      );
      assign n_sum[NCH+c] = SUMW'(corr);
      assign n_pk[NCH+c]  = corr;
      assign n_ix[NCH+c]  = IW'(c);
    end

    for (n = 1; n < NCH; n++) begin : g_node
      qsp_merge_node #(.SUMW(SUMW), .VW(VW), .IW(IW), .TW(TW)) u_node (
        .clk(clk), .rst_n(rst_n),
        .sum_a(n_sum[2*n]),   .pk_a(n_pk[2*n]),   .ix_a(n_ix[2*n]),
        .h_a(n_h[2*n]),       .t_a(n_t[2*n]),
        .sum_b(n_sum[2*n+1]), .pk_b(n_pk[2*n+1]), .ix_b(n_ix[2*n+1]),
        .h_b(n_h[2*n+1]),     .t_b(n_t[2*n+1]),
        .sum_q(n_sum[n]), .pk_q(n_pk[n]), .ix_q(n_ix[n]), .h_q(n_h[n]), .t_q(n_t[n])
      );
    end
  endgenerate

  assign res_word = {n_h[1], n_t[1], n_ix[1], n_pk[1], n_sum[1]};

  // R3: total charge can never fall below the single largest channel
  a_r3_sum_covers_peak: assert property (@(posedge clk) disable iff (!rst_n)
    res_word[SUMW-1:0] >= SUMW'(res_word[SUMW +: VW]));
endmodule

// File: tb/qsp_reduce_top_test.sv
module qsp_reduce_top_test;
  localparam int NCH = 16;
  localparam int SW  = 10;
  localparam int TW  = 8;

  logic              clk;
  logic              rst_n;
  logic [NCH*SW-1:0] smp_data;
  logic [NCH-1:0]    smp_hit;
  logic [NCH*TW-1:0] smp_time;
  logic              cfg_we;
  logic              cfg_kind;
  logic [3:0]        cfg_ch;
  logic [9:0]        cfg_data;
  logic [38:0]       res_word;

  int checks = 0;
  int errors = 0;

  int raw_m  [NCH];
  int hit_m  [NCH];
  int time_m [NCH];
  int gain_m [NCH];
  int ped_m  [NCH];

  qsp_reduce_top uut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_hit(smp_hit),
    .smp_time(smp_time), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_ch(cfg_ch), .cfg_data(cfg_data), .res_word(res_word)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int corr_of(input int k);
    int s;
    s = (raw_m[k] * gain_m[k]) / 64;
    if (s > 2047) s = 2047;
    s = s - ped_m[k];
    if (s < 0) s = 0;
    return s;
  endfunction

  function automatic logic [38:0] expect_word();
    int sum, pk, ix, tm, any;
    sum = 0; pk = -1; ix = 0; tm = 0; any = 0;
    for (int k = 0; k < NCH; k++) begin
      int v;
      v = corr_of(k);
      sum += v;
      if (v > pk) begin pk = v; ix = k; end
      if (hit_m[k] != 0) begin
        if (any == 0 || time_m[k] < tm) tm = time_m[k];
        any = 1;
      end
    end
    return {any[0], tm[7:0], ix[3:0], pk[10:0], sum[14:0]};
  endfunction

  task automatic drive();
    for (int k = 0; k < NCH; k++) begin
      smp_data[k*SW +: SW] = raw_m[k][SW-1:0];
      smp_hit[k]           = hit_m[k][0];
      smp_time[k*TW +: TW] = time_m[k][TW-1:0];
    end
  endtask

  task automatic check_fields(input logic [38:0] exp, input string tag);
    check(res_word[14:0]  == exp[14:0],  {tag, " R3 sum"},   res_word[14:0],  exp[14:0]);
    check(res_word[25:15] == exp[25:15], {tag, " R4 peak"},  res_word[25:15], exp[25:15]);
    check(res_word[29:26] == exp[29:26], {tag, " R5 index"}, res_word[29:26], exp[29:26]);
    check(res_word[37:30] == exp[37:30], {tag, " R6 time"},  res_word[37:30], exp[37:30]);
    check(res_word[38]    == exp[38],    {tag, " R7 flag"},  res_word[38],    exp[38]);
  endtask

  task automatic apply_check(input string tag);
    logic [38:0] e;
    drive();
    e = expect_word();
    repeat (5) @(negedge clk);
    check_fields(e, tag);
  endtask

  task automatic cfg_write(input int kind, input int ch, input int val);
    cfg_we = 1'b1; cfg_kind = kind[0]; cfg_ch = ch[3:0]; cfg_data = val[9:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (kind == 0) gain_m[ch] = val & 255;
    else           ped_m[ch]  = val & 1023;
  endtask

  task automatic t_reset();
    repeat (6) @(negedge clk);
    check(res_word == 39'd0, "R9 reset word", res_word, 0);
    for (int k = 0; k < NCH; k++) raw_m[k] = 100 + k;
    apply_check("R9 unity gain zero pedestal R2");
  endtask

  task automatic t_unity_pattern();
    for (int k = 0; k < NCH; k++) begin
      raw_m[k] = (k * 211 + 37) % 1024;
      hit_m[k] = 1;
      time_m[k] = 200 - k * 7;
    end
    apply_check("R3 R4 R6 pattern A");
    for (int k = 0; k < NCH; k++) begin
      raw_m[k]  = 1023 - k * 50;
      hit_m[k]  = k % 3 == 0;
      time_m[k] = (k * 37) % 256;
    end
    time_m[1] = 0;
    apply_check("R6 unflagged early time ignored");
  endtask

  task automatic t_gain_ped();
    cfg_write(0, 0, 255);
    cfg_write(0, 1, 32);
    cfg_write(0, 2, 0);
    cfg_write(1, 3, 900);
    cfg_write(1, 4, 10);
    cfg_write(0, 5, 200);
    cfg_write(1, 5, 5);
    for (int k = 0; k < NCH; k++) begin
      raw_m[k] = 500; hit_m[k] = 0; time_m[k] = 9;
    end
    raw_m[0] = 1023;
    raw_m[5] = 1000;
    apply_check("R2 R8 saturation and clamp");
    check(res_word[29:26] == 4'd0, "R2 saturated channel is peak", res_word[29:26], 0);
    check(res_word[25:15] == 11'd2047, "R2 saturation to 2047", res_word[25:15], 2047);
    for (int k = 0; k < NCH; k++) begin
      if (k != 0) cfg_write(0, k, 64);
      cfg_write(1, k, 0);
    end
    cfg_write(0, 0, 64);
  endtask

  task automatic t_write_timing();
    for (int k = 0; k < NCH; k++) begin raw_m[k] = 0; hit_m[k] = 0; end
    raw_m[7] = 640;
    drive();
    cfg_we = 1'b1; cfg_kind = 1'b0; cfg_ch = 4'd7; cfg_data = 10'd128;
    @(negedge clk);
    cfg_we = 1'b0;
    gain_m[7] = 128;
    repeat (5) @(negedge clk);
    check(res_word[25:15] == 11'd1280, "R8 gain used next edge", res_word[25:15], 1280);
    cfg_write(0, 7, 64);
  endtask

  task automatic t_ties();
    for (int k = 0; k < NCH; k++) begin raw_m[k] = 20; hit_m[k] = 0; end
    raw_m[3] = 700; raw_m[11] = 700;
    apply_check("R5 tie lower index");
    check(res_word[29:26] == 4'd3, "R5 tie index", res_word[29:26], 3);
    for (int k = 0; k < NCH; k++) raw_m[k] = 0;
    apply_check("R5 all zero");
    check(res_word[29:26] == 4'd0, "R5 all zero index", res_word[29:26], 0);
  endtask

  task automatic t_hits();
    for (int k = 0; k < NCH; k++) begin raw_m[k] = 10 * k; hit_m[k] = 0; time_m[k] = 33 + k; end
    apply_check("R7 no hit");
    check(res_word[38:30] == 9'd0, "R7 no hit flag and time", res_word[38:30], 0);
    hit_m[15] = 1;
    apply_check("R6 single hit last channel");
    check(res_word[37:30] == 8'd48, "R6 single hit time", res_word[37:30], 48);
  endtask

  task automatic t_stream();
    logic [38:0] ea, eb;
    for (int k = 0; k < NCH; k++) begin raw_m[k] = 0; hit_m[k] = 0; time_m[k] = 0; end
    drive();
    repeat (6) @(negedge clk);
    raw_m[2] = 300; hit_m[2] = 1; time_m[2] = 77;
    drive(); ea = expect_word();
    @(negedge clk);
    raw_m[2] = 0; raw_m[9] = 555; hit_m[2] = 0; hit_m[9] = 1; time_m[9] = 12;
    drive(); eb = expect_word();
    repeat (3) @(negedge clk);
    check(res_word == 39'd0, "R1 not yet visible after 4 edges", res_word, 0);
    @(negedge clk);
    check(res_word == ea, "R1 first word after 5 edges", res_word, ea);
    @(negedge clk);
    check(res_word == eb, "R1 next word one clock later", res_word, eb);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_kind = 1'b0; cfg_ch = '0; cfg_data = '0;
    for (int k = 0; k < NCH; k++) begin
      raw_m[k] = 0; hit_m[k] = 0; time_m[k] = 0; gain_m[k] = 64; ped_m[k] = 0;
    end
    drive();
    repeat (3) @(negedge clk);
    check(res_word == 39'd0, "R9 word in reset", res_word, 0);
    rst_n = 1'b1;
    t_reset();
    t_unity_pattern();
    t_gain_ped();
    t_write_timing();
    t_ties();
    t_hits();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule